// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port memory and decides, cycle by cycle, which of the two ports may keep writing when both point at the same word. Each port presents an enable, a write strobe and an address. When both ports are enabled on the same address, the block flags a contention. It then chooses exactly one winner from the order in which the two accesses began, counted in clock cycles. An access begins in the cycle its port becomes enabled, or in the cycle an enabled port moves to a new address.

The losing port receives an active-low busy indication, and its write strobe is masked. Reads are not touched by the block. If the two accesses began within `TIE_WIN` cycles of each other, the left port wins by a fixed tie-break. If the right port began more than `TIE_WIN` cycles before the left port, the right port wins. The decision is latched for as long as the contention lasts. Busy is released in the same cycle the addresses stop matching.

A mode input lets several of these blocks be combined for wider or deeper memories. In master mode the block arbitrates and drives the busy outputs. In slave mode its own arbitration is ignored and its busy outputs stay high. In that mode the block takes the busy indications of a master on separate inputs and uses them to mask the local writes.

Top module: `dual_port_contention_arbiter`

## Requirements
- R1: A busy output (active low) is asserted only while both ports are enabled and their addresses are equal; otherwise both busy outputs read 1.
- R2: In master mode (masterMode = 1), in every cycle where a match exists, exactly one busy output is 0, in that same cycle with no register delay.
- R3: When the left access began no more than TIE_WIN cycles after the right access, including the same cycle, the left port wins and rightBusyN is 0.
- R4: When the right access began more than TIE_WIN cycles before the left access, the right port wins and leftBusyN is 0.
- R5: Once made, the decision holds unchanged for every cycle the match lasts without either port starting a new access.
- R6: Both busy outputs return to 1 in the first cycle the addresses differ or either enable drops.
- R7: A port whose address changes while it is enabled starts a new access in that cycle, and the winner is decided again from the new start cycles.
- R8: A port is blocked when master mode has busied it, or when slave mode sees its busy input at 0. A port's gated write strobe is enable AND write AND NOT blocked. Its write-inhibit output is enable AND write AND blocked.
- R9: In slave mode (masterMode = 0), both busy outputs stay 1, and each port is blocked exactly when its busy input is 0.
- R10: In master mode the busy inputs have no effect on any output.
- R11: While reset (rstN = 0) is held with both ports idle, busy outputs read 1 and gated strobes and inhibits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterMode | input | 1 | 1 = arbitrate and drive busy, 0 = obey busy inputs |
| leftEn | input | 1 | Left port enable, active high |
| leftWe | input | 1 | Left port write strobe, active high |
| leftAddr | input | ADDR_W | Left port address |
| rightEn | input | 1 | Right port enable, active high |
| rightWe | input | 1 | Right port write strobe, active high |
| rightAddr | input | ADDR_W | Right port address |
| leftBusyInN | input | 1 | Slave-mode busy for the left port, active low |
| rightBusyInN | input | 1 | Slave-mode busy for the right port, active low |
| leftBusyN | output | 1 | Left port busied, active low |
| rightBusyN | output | 1 | Right port busied, active low |
| leftWeGate | output | 1 | Left write strobe after masking |
| rightWeGate | output | 1 | Right write strobe after masking |
| leftWrBlock | output | 1 | Left write requested but inhibited |
| rightWrBlock | output | 1 | Right write requested but inhibited |

## Verification
The bench builds the block with ADDR_W = 3, AGE_W = 4 and TIE_WIN = 1. A 3-bit address makes it practical to sweep all 64 address pairs, in master mode, against every start offset from three cycles left-first to three cycles right-first. With TIE_WIN = 1, that offset range lands on both sides of the tie window, so the tie-break and both strict-order outcomes are all exercised. The age counters never saturate inside these short scenarios. In slave mode every combination of enables, write strobes and busy inputs is exercised. A directed sequence moves an enabled port away and back to check that the decision is made again.

// File: rtl/dpca_pkg.sv
package dpca_pkg;

  // Status flags that the datapath reports to the control each cycle.
  typedef struct packed {
    logic match;         // both enabled, addresses equal
    logic contStart;     // first cycle of a contention episode
    logic rightEarlier;  // right began more than TIE_WIN cycles before left
  } arbStatus_t;

  // Strobes that the control returns to the datapath.
  typedef struct packed {
    logic blockLeft;
    logic blockRight;
  } arbStrobe_t;

  localparam int PORTS = 2;
  localparam int LEFT  = 0;
  localparam int RIGHT = 1;

endpackage

// File: rtl/dpca_datapath.sv
module dpca_datapath
  import dpca_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int AGE_W   = 4,
  parameter int TIE_WIN = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftEn,
  input  logic              leftWe,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightEn,
  input  logic              rightWe,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              leftBusyInN,
  input  logic              rightBusyInN,
  input  arbStrobe_t        strobe,
  output arbStatus_t        status,
  output logic              leftBusyN,
  output logic              rightBusyN,
  output logic              leftWeGate,
  output logic              rightWeGate,
  output logic              leftWrBlock,
  output logic              rightWrBlock
);

  localparam int CMP_W = AGE_W + 2;
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
  localparam logic [CMP_W-1:0] TIE_V   = CMP_W'(TIE_WIN);

  logic [PORTS-1:0]  enV;
  logic [PORTS-1:0]  weV;
  logic [PORTS-1:0]  extBusy;
  logic [PORTS-1:0]  blockV;
  logic [PORTS-1:0]  newAcc;
  logic [ADDR_W-1:0] addrV   [PORTS];
  logic [AGE_W-1:0]  curAge  [PORTS];

  assign enV[LEFT]      = leftEn;
  assign enV[RIGHT]     = rightEn;
  assign weV[LEFT]      = leftWe;
  assign weV[RIGHT]     = rightWe;
  assign addrV[LEFT]    = leftAddr;
  assign addrV[RIGHT]   = rightAddr;
  assign extBusy[LEFT]  = ~leftBusyInN;
  assign extBusy[RIGHT] = ~rightBusyInN;

  // Per-port access tracking: start detection and age since start.
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic              enPrev;
    logic [ADDR_W-1:0] addrPrev;
    logic [AGE_W-1:0]  ageReg;
    logic [AGE_W-1:0]  ageNext;

    assign newAcc[p] = enV[p] & (~enPrev | (addrV[p] != addrPrev));
    assign curAge[p] = newAcc[p] ? '0 : ageReg;
    assign ageNext   = (curAge[p] == AGE_MAX) ? curAge[p] : curAge[p] + 1'b1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enPrev   <= 1'b0;
        addrPrev <= '0;
        ageReg   <= '0;
      end else begin
        enPrev   <= enV[p];
        addrPrev <= addrV[p];
        ageReg   <= enV[p] ? ageNext : '0;
      end
    end
  end

  // Contention detection.
  logic matchNow;
  logic matchPrev;

  assign matchNow = (&enV) & (addrV[LEFT] == addrV[RIGHT]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchPrev <= 1'b0;
    else       matchPrev <= matchNow;
  end

  assign status.match        = matchNow;
  assign status.contStart    = matchNow & (~matchPrev | (|newAcc));
  assign status.rightEarlier = {2'b00, curAge[RIGHT]} > ({2'b00, curAge[LEFT]} + TIE_V);

  // Blocking source depends on mode.
  assign blockV[LEFT]  = masterMode ? strobe.blockLeft  : extBusy[LEFT];
  assign blockV[RIGHT] = masterMode ? strobe.blockRight : extBusy[RIGHT];

  assign leftBusyN    = ~(masterMode & strobe.blockLeft);
  assign rightBusyN   = ~(masterMode & strobe.blockRight);
  assign leftWeGate   = enV[LEFT]  & weV[LEFT]  & ~blockV[LEFT];
  assign rightWeGate  = enV[RIGHT] & weV[RIGHT] & ~blockV[RIGHT];
  assign leftWrBlock  = enV[LEFT]  & weV[LEFT]  &  blockV[LEFT];
  assign rightWrBlock = enV[RIGHT] & weV[RIGHT] &  blockV[RIGHT];

  // R1: a busy output only with both enabled on one address
  p_busy_needs_match_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!leftBusyN || !rightBusyN) |-> (leftEn && rightEn && leftAddr == rightAddr));

  // R9: slave mode never drives busy
  p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (leftBusyN && rightBusyN));

  // R8: a busied port never passes a write strobe
  p_busied_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !leftBusyN) |-> !leftWeGate);

  // R8: gated strobe and inhibit are never both high
  p_gate_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(rightWeGate && rightWrBlock));

endmodule

// File: rtl/dpca_control.sv
module dpca_control
  import dpca_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  arbStatus_t status,
  output arbStrobe_t strobe
);

  logic winRightReg;
  logic winRight;

  // Decide fresh at the start of an episode, otherwise reuse the latch.
  assign winRight = status.contStart ? status.rightEarlier : winRightReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 winRightReg <= 1'b0;
    else if (status.contStart) winRightReg <= status.rightEarlier;
  end

  assign strobe.blockLeft  = status.match &  winRight;
  assign strobe.blockRight = status.match & ~winRight;

  // R2: exactly one loser while a match exists
  p_one_loser_r2: assert property (@(posedge clk) disable iff (!rstN)
    status.match |-> ($countones({strobe.blockLeft, strobe.blockRight}) == 1));

  // R5: decision stays put through a continuing episode
  p_hold_decision_r5: assert property (@(posedge clk) disable iff (!rstN)
    (status.match && !status.contStart) |-> (strobe.blockLeft == $past(strobe.blockLeft)));

  // R6: no block without a match
  p_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    !status.match |-> (!strobe.blockLeft && !strobe.blockRight));

endmodule

// File: rtl/dual_port_contention_arbiter.sv
module dual_port_contention_arbiter
  import dpca_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int AGE_W   = 4,
  parameter int TIE_WIN = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              leftEn,
  input  logic              leftWe,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightEn,
  input  logic              rightWe,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              leftBusyInN,
  input  logic              rightBusyInN,
  output logic              leftBusyN,
  output logic              rightBusyN,
  output logic              leftWeGate,
  output logic              rightWeGate,
  output logic              leftWrBlock,
  output logic              rightWrBlock
);

  arbStatus_t status;
  arbStrobe_t strobe;

  dpca_datapath #(
    .ADDR_W (ADDR_W),
    .AGE_W  (AGE_W),
    .TIE_WIN(TIE_WIN)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .masterMode  (masterMode),
    .leftEn      (leftEn),
    .leftWe      (leftWe),
    .leftAddr    (leftAddr),
    .rightEn     (rightEn),
    .rightWe     (rightWe),
    .rightAddr   (rightAddr),
    .leftBusyInN (leftBusyInN),
    .rightBusyInN(rightBusyInN),
    .strobe      (strobe),
    .status      (status),
    .leftBusyN   (leftBusyN),
    .rightBusyN  (rightBusyN),
    .leftWeGate  (leftWeGate),
    .rightWeGate (rightWeGate),
    .leftWrBlock (leftWrBlock),
    .rightWrBlock(rightWrBlock)
  );

  dpca_control u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .status(status),
    .strobe(strobe)
  );

endmodule

// File: tb/sim_dual_port_contention_arbiter.sv
module sim_dual_port_contention_arbiter;

  localparam int ADDR_W  = 3;
  localparam int AGE_W   = 4;
  localparam int TIE_WIN = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic leftEn = 1'b0, leftWe = 1'b0, rightEn = 1'b0, rightWe = 1'b0;
  logic [ADDR_W-1:0] leftAddr = '0, rightAddr = '0;
  logic leftBusyInN = 1'b1, rightBusyInN = 1'b1;
  logic leftBusyN, rightBusyN, leftWeGate, rightWeGate, leftWrBlock, rightWrBlock;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dual_port_contention_arbiter #(
    .ADDR_W(ADDR_W), .AGE_W(AGE_W), .TIE_WIN(TIE_WIN)
  ) u0 (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .leftEn(leftEn), .leftWe(leftWe), .leftAddr(leftAddr),
    .rightEn(rightEn), .rightWe(rightWe), .rightAddr(rightAddr),
    .leftBusyInN(leftBusyInN), .rightBusyInN(rightBusyInN),
    .leftBusyN(leftBusyN), .rightBusyN(rightBusyN),
    .leftWeGate(leftWeGate), .rightWeGate(rightWeGate),
    .leftWrBlock(leftWrBlock), .rightWrBlock(rightWrBlock)
  );

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs {lb,rb,lg,rg,lw,rw} actual=%b expected=%b at %0t",
               tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] outs();
    return {leftBusyN, rightBusyN, leftWeGate, rightWeGate, leftWrBlock, rightWrBlock};
  endfunction

  // Advance to just after the next rising edge, ready to drive.
  task automatic nextCycle();
    @(posedge clk);
    #1;
  endtask

  // Drive both ports for one cycle, then sample mid-cycle.
  task automatic drive(input logic eL, input logic [ADDR_W-1:0] aL,
                       input logic eR, input logic [ADDR_W-1:0] aR);
    nextCycle();
    leftEn = eL; leftAddr = aL; rightEn = eR; rightAddr = aR;
    #6;
  endtask

  // Master sweep: R1-style match, R2 one loser, R3/R4 order, R5 hold, R8 gating, R10 busy inputs ignored.
  task automatic runPair(input int aL, input int aR, input int off);
    int sL, sR;
    logic rw, m, eL, eR;
    sL = (off < 0) ? -off : 0;
    sR = (off > 0) ?  off : 0;
    rw = ((sL - sR) > TIE_WIN);
    masterMode = 1'b1;
    leftWe = 1'b1; rightWe = 1'b1;
    leftBusyInN = 1'b0; rightBusyInN = 1'b0;   // asserted, must be ignored (R10)
    drive(1'b0, '0, 1'b0, '0);
    for (int c = 0; c < 6; c++) begin
      eL = (c >= sL);
      eR = (c >= sR);
      drive(eL, ADDR_W'(aL), eR, ADDR_W'(aR));
      m = eL && eR && (aL == aR);
      if (!m)
        chk("R1/R6/R10 no match", outs(), {1'b1, 1'b1, eL, eR, 1'b0, 1'b0});
      else if (rw)
        chk("R2/R4/R5/R8 right wins", outs(), {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0});
      else
        chk("R2/R3/R5/R8 left wins", outs(), {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1});
    end
  endtask

  initial begin
    // R11: reset state with idle ports
    #3;
    chk("R11 reset", outs(), 6'b110000);
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    #5;
    chk("R11 after reset", outs(), 6'b110000);

    // Exhaustive master sweep over address pairs and start offsets.
    for (int aL = 0; aL < (1 << ADDR_W); aL++)
      for (int aR = 0; aR < (1 << ADDR_W); aR++)
        for (int off = -3; off <= 3; off++)
          runPair(aL, aR, off);

    // R7 directed: re-arrival after an address change flips the winner.
    masterMode = 1'b1; leftWe = 1'b1; rightWe = 1'b1;
    leftBusyInN = 1'b1; rightBusyInN = 1'b1;
    drive(1'b0, 3'd0, 1'b0, 3'd0);
    drive(1'b1, 3'd2, 1'b0, 3'd2);
    chk("R1 left alone", outs(), 6'b111000);
    drive(1'b1, 3'd2, 1'b1, 3'd2);
    chk("R3 left earlier wins", outs(), 6'b101001);
    drive(1'b1, 3'd2, 1'b1, 3'd2);
    chk("R5 hold", outs(), 6'b101001);
    drive(1'b1, 3'd2, 1'b1, 3'd2);
    chk("R5 hold again", outs(), 6'b101001);
    drive(1'b1, 3'd3, 1'b1, 3'd2);
    chk("R6 release on mismatch", outs(), 6'b111100);
    drive(1'b1, 3'd2, 1'b1, 3'd2);
    chk("R7 re-arrival right wins", outs(), 6'b010110);
    drive(1'b1, 3'd2, 1'b1, 3'd2);
    chk("R7 R4 held", outs(), 6'b010110);
    drive(1'b1, 3'd2, 1'b0, 3'd2);
    chk("R6 release on enable drop", outs(), 6'b111000);

    // R9 slave sweep: all enables, strobes and busy inputs, same address.
    masterMode = 1'b0;
    for (int v = 0; v < 64; v++) begin
      logic eL, eR, wL, wR, bL, bR;
      {eL, eR, wL, wR, bL, bR} = 6'(v);
      nextCycle();
      leftEn = eL; rightEn = eR; leftWe = wL; rightWe = wR;
      leftBusyInN = bL; rightBusyInN = bR;
      leftAddr = 3'd5; rightAddr = 3'd5;
      #6;
      chk("R9/R8 slave gating", outs(),
          {1'b1, 1'b1, eL & wL & bL, eR & wR & bR, eL & wL & ~bL, eR & wR & ~bR});
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_900_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule